// File: doc/BRIEF.md
# Complex NCO Downconversion Mixer

This block moves a real, digitised intermediate-frequency sample stream down to complex baseband. A 32-bit phase accumulator steps by a programmable tuning word once for each accepted sample. A static phase-offset word is added to the accumulator so that several mixers on one chip, or on several chips, can be placed in a known phase relationship. The top bits of that sum address a quarter-wave sine table, and symmetry rebuilds the full sine and cosine. Each input sample is multiplied by the cosine to form I and by the negated sine to form Q. Both products are rounded to 16 bits.

Two kinds of dither can each be switched on alone to break up spurious tones. Phase dither adds a pseudorandom value, taken from a 15-bit shift register, below the table address. Amplitude dither nudges the looked-up sine and cosine by one LSB up or down. The stream has no handshake. A sample is taken on every clock where the valid strobe is high, and the result comes out a fixed number of cycles later. A synchronous clear restarts the accumulator and the dither sequence. In a multi-channel receiver, one instance sits in front of each channel's decimation chain.

Top module: `nco_mixer`

## Requirements
- R1: While reset is asserted, and after it is released with no input, `outValid` is 0 and `outI` and `outQ` are 0.
- R2: Every input cycle with `inValid` high produces exactly one output cycle with `outValid` high, 4 clock cycles later. The order and the gaps of the input are preserved, and `outI`/`outQ` hold their values between valid outputs.
- R3: The accumulator adds `freqWord` (modulo 2^32) once per valid sample and holds otherwise. A sample uses the accumulator value from before that sample's update.
- R4: The table address for a sample is bits [31:20] of (accumulator + `phaseOffset` + phase dither term), taken modulo 2^32.
- R5: With T[k] = round(32767·sin(2π(k+0.5)/4096)) for k in 0..1023, the sine at address a is computed from q = a[11:10] and k = a[9:0]. It equals T[k] when q=0, T[1023−k] when q=1, −T[k] when q=2 and −T[1023−k] when q=3. The cosine at a equals the sine at (a+1024) mod 4096.
- R6: For a signed 12-bit sample x, `outI` = floor((x·cos + 1024)/2048) and `outQ` = floor((−x·sin + 1024)/2048), both signed 16-bit. A zero sample gives zero outputs.
- R7: `clear` sets the accumulator to 0 and the dither register to 1 at the next edge. A sample taken in the same cycle still uses the accumulator value from before the clear.
- R8: The dither register is 15 bits, starts at 1 and steps to {s[13:0], s[14]^s[13]} on every valid sample whether or not dither is enabled. When `phaseDitherEn` is high, the phase dither term is the register value shifted left by 5 (it occupies bits [19:5]); when low, the term is 0.
- R9: When `ampDitherEn` is high, the register's bits [1:0] pick the step: 01 adds +1 to both sine and cosine, 10 adds −1, and 00 or 11 add nothing. The result is clamped to ±32767. When `ampDitherEn` is low, the step is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart of accumulator and dither register |
| freqWord | input | 32 | Phase increment per sample |
| phaseOffset | input | 32 | Static phase added after the accumulator |
| phaseDitherEn | input | 1 | Enables phase dither |
| ampDitherEn | input | 1 | Enables amplitude dither |
| inValid | input | 1 | Input sample strobe |
| inSample | input | 12 | Real input sample, two's complement |
| outValid | output | 1 | Output sample strobe |
| outI | output | 16 | In-phase result, two's complement |
| outQ | output | 16 | Quadrature result, two's complement |

## Verification
Each product pair is due exactly four clock edges after the edge that accepts its input sample. The bench stamps every sample it drives with the current cycle number plus four and queues that stamp together with the I/Q values predicted from R3 to R9. It samples the outputs on the falling edge. Whenever `outValid` is high, it checks that the cycle number equals the stamp at the head of the queue before it compares values. A clear takes effect at the next rising edge, so the bench model restarts its accumulator and dither register at that same point. After the last sample, a drained queue shows that no output was lost or added.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // Amplitude dither step codes carried with each sample
  localparam logic [1:0] STEP_UP   = 2'b01;
  localparam logic [1:0] STEP_DOWN = 2'b10;

  // Strobes from control to datapath, one per pipeline stage
  typedef struct packed {
    logic       ldSample;   // stage 1: capture input sample
    logic       ldLookup;   // stage 2: table read
    logic       ldSign;     // stage 3: sign fold and dither
    logic       ldProduct;  // stage 4: multiply and round
    logic [1:0] ampStep;    // dither step travelling with stage 2
  } nco_strobe_t;

endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 12,
  parameter int LFSR_W  = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clear,
  input  logic               inValid,
  input  logic [PHASE_W-1:0] freqWord,
  input  logic [PHASE_W-1:0] phaseOffset,
  input  logic               phaseDitherEn,
  input  logic               ampDitherEn,
  output nco_strobe_t        strb,
  output logic [ADDR_W-1:0]  addr,
  output logic               outValid
);

  localparam int DITH_SHIFT = PHASE_W - ADDR_W - LFSR_W;
  localparam int ADDR_LSB   = PHASE_W - ADDR_W;
  localparam logic [LFSR_W-1:0] LFSR_SEED = LFSR_W'(1);

  logic [PHASE_W-1:0] acc;
  logic [PHASE_W-1:0] ditherTerm;
  logic [PHASE_W-1:0] phaseSum;
  logic [LFSR_W-1:0]  lfsr;
  logic [LFSR_W-1:0]  lfsrNext;
  logic [3:0]         vldPipe;
  logic [1:0]         ampStepQ;

  always_comb begin
    lfsrNext   = {lfsr[LFSR_W-2:0], lfsr[LFSR_W-1] ^ lfsr[LFSR_W-2]};
    ditherTerm = '0;
    if (phaseDitherEn) ditherTerm = PHASE_W'(lfsr) << DITH_SHIFT;
    phaseSum   = acc + phaseOffset + ditherTerm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '0;
      lfsr     <= LFSR_SEED;
      vldPipe  <= '0;
      addr     <= '0;
      ampStepQ <= '0;
    end else begin
      vldPipe <= {vldPipe[2:0], inValid};
      if (inValid) begin
        addr     <= ADDR_W'(phaseSum >> ADDR_LSB);
        ampStepQ <= ampDitherEn ? lfsr[1:0] : 2'b00;
      end
      if (clear) begin
        acc  <= '0;
        lfsr <= LFSR_SEED;
      end else if (inValid) begin
        acc  <= acc + freqWord;
        lfsr <= lfsrNext;
      end
    end
  end

  always_comb begin
    strb.ldSample  = inValid;
    strb.ldLookup  = vldPipe[0];
    strb.ldSign    = vldPipe[1];
    strb.ldProduct = vldPipe[2];
    strb.ampStep   = ampStepQ;
  end

  assign outValid = vldPipe[3];

  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (acc == '0) && (lfsr == LFSR_SEED)); // R7
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && !inValid) |=> $stable(acc) && $stable(lfsr)); // R3
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0); // R8
  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 4)); // R2

endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 12,
  parameter int AMP_W  = 16,
  parameter int OUT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  nco_strobe_t              strb,
  input  logic [ADDR_W-1:0]        addr,
  input  logic signed [DATA_W-1:0] inSample,
  output logic signed [OUT_W-1:0]  outI,
  output logic signed [OUT_W-1:0]  outQ
);

  localparam int QW     = ADDR_W - 2;
  localparam int QD     = 1 << QW;
  localparam int MAG_W  = AMP_W - 1;
  localparam int FULL   = (1 << MAG_W) - 1;
  localparam int PROD_W = DATA_W + AMP_W + 1;
  localparam int SHIFT  = DATA_W + AMP_W - 1 - OUT_W;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(2 ** (SHIFT - 1));

  function automatic logic [MAG_W-1:0] romEntry(input int k);
    real ang;
    ang = 6.283185307179586 * (real'(k) + 0.5) / real'(4 * QD);
    return MAG_W'($rtoi(real'(FULL) * $sin(ang) + 0.5));
  endfunction

  function automatic logic signed [AMP_W-1:0] foldStep(
    input logic [MAG_W-1:0] mag, input logic neg, input logic [1:0] step);
    logic signed [AMP_W:0] v;
    v = signed'({2'b00, mag});
    if (neg) v = -v;
    if (step == STEP_UP) v = v + 1'sb1 * -1;
    if (step == STEP_DOWN) v = v - (AMP_W+1)'(1);
    if (int'(v) > FULL) v = (AMP_W+1)'(FULL);
    if (int'(v) < -FULL) v = -(AMP_W+1)'(FULL);
    return v[AMP_W-1:0];
  endfunction

  // Quarter-wave table, built from its defining formula
  logic [MAG_W-1:0] quarterRom [QD];
  for (genvar k = 0; k < QD; k++) begin : g_rom
    assign quarterRom[k] = romEntry(k);
  end

  logic [ADDR_W-1:0]        cosAddr;
  logic [QW-1:0]            sinIdx, cosIdx;
  logic signed [DATA_W-1:0] sample1, sample2, sample3;
  logic [MAG_W-1:0]         magS, magC;
  logic                     negS, negC;
  logic [1:0]               step2;
  logic signed [AMP_W-1:0]  sinV, cosV;
  logic signed [PROD_W-1:0] prodI, prodQ, sumI, sumQ;

  always_comb begin
    cosAddr = addr + ADDR_W'(QD);
    sinIdx  = addr[ADDR_W-2]    ? ~addr[QW-1:0]    : addr[QW-1:0];
    cosIdx  = cosAddr[ADDR_W-2] ? ~cosAddr[QW-1:0] : cosAddr[QW-1:0];
    prodI   = PROD_W'(sample3) * PROD_W'(cosV);
    prodQ   = -(PROD_W'(sample3) * PROD_W'(sinV));
    sumI    = prodI + HALF;
    sumQ    = prodQ + HALF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sample1 <= '0;
      sample2 <= '0;
      sample3 <= '0;
      magS    <= '0;
      magC    <= '0;
      negS    <= 1'b0;
      negC    <= 1'b0;
      step2   <= '0;
      sinV    <= '0;
      cosV    <= '0;
      outI    <= '0;
      outQ    <= '0;
    end else begin
      if (strb.ldSample) sample1 <= inSample;
      if (strb.ldLookup) begin
        sample2 <= sample1;
        magS    <= quarterRom[sinIdx];
        magC    <= quarterRom[cosIdx];
        negS    <= addr[ADDR_W-1];
        negC    <= cosAddr[ADDR_W-1];
        step2   <= strb.ampStep;
      end
      if (strb.ldSign) begin
        sample3 <= sample2;
        sinV    <= foldStep(magS, negS, step2);
        cosV    <= foldStep(magC, negC, step2);
      end
      if (strb.ldProduct) begin
        outI <= OUT_W'(sumI >>> SHIFT);
        outQ <= OUT_W'(sumQ >>> SHIFT);
      end
    end
  end

  int absSin;
  assign absSin = (sinV < 0) ? -int'(sinV) : int'(sinV);

  AST_SIN_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldSign |=> (absSin <= int'($past(magS)) + 1) && (absSin >= int'($past(magS)) - 1)); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ldProduct |=> $stable(outI) && $stable(outQ)); // R2
  AST_ZERO_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ldProduct && sample3 == '0) |=> (outI == '0) && (outQ == '0)); // R6

endmodule

// File: rtl/nco_mixer.sv
module nco_mixer
  import nco_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 12,
  parameter int LFSR_W  = 15,
  parameter int DATA_W  = 12,
  parameter int AMP_W   = 16,
  parameter int OUT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clear,
  input  logic [PHASE_W-1:0] freqWord,
  input  logic [PHASE_W-1:0] phaseOffset,
  input  logic               phaseDitherEn,
  input  logic               ampDitherEn,
  input  logic               inValid,
  input  logic [DATA_W-1:0]  inSample,
  output logic               outValid,
  output logic [OUT_W-1:0]   outI,
  output logic [OUT_W-1:0]   outQ
);

  nco_strobe_t              strb;
  logic [ADDR_W-1:0]        addr;
  logic signed [OUT_W-1:0]  iOut, qOut;

  nco_ctrl #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .LFSR_W(LFSR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .clear(clear), .inValid(inValid),
    .freqWord(freqWord), .phaseOffset(phaseOffset),
    .phaseDitherEn(phaseDitherEn), .ampDitherEn(ampDitherEn),
    .strb(strb), .addr(addr), .outValid(outValid)
  );

  nco_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr),
    .inSample(signed'(inSample)), .outI(iOut), .outQ(qOut)
  );

  assign outI = iOut;
  assign outQ = qOut;

endmodule

// File: tb/tb_nco_mixer.sv
module tb_nco_mixer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clear = 1'b0;
  logic [31:0] freqWord = '0;
  logic [31:0] phaseOffset = '0;
  logic        phaseDitherEn = 1'b0;
  logic        ampDitherEn = 1'b0;
  logic        inValid = 1'b0;
  logic [11:0] inSample = '0;
  logic        outValid;
  logic [15:0] outI, outQ;

  always #10 clk = ~clk;  // 50 MHz

  nco_mixer dut (
    .clk(clk), .rstN(rstN), .clear(clear), .freqWord(freqWord),
    .phaseOffset(phaseOffset), .phaseDitherEn(phaseDitherEn),
    .ampDitherEn(ampDitherEn), .inValid(inValid), .inSample(inSample),
    .outValid(outValid), .outI(outI), .outQ(outQ)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [31:0] accM = '0;
  logic [14:0] lfsrM = 15'd1;
  int qI[$], qQ[$], qCyc[$];
  string qTag[$];

  localparam int NV = 8;
  localparam logic [31:0] V_FREQ [NV] = '{32'h0000_0000, 32'h4000_0000, 32'h1234_5678,
    32'h0010_0000, 32'hFFF0_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h0ABC_DEF0};
  localparam logic [31:0] V_OFF [NV] = '{32'h0000_0000, 32'h0000_0000, 32'h8000_0000,
    32'h3FF0_0000, 32'h0008_0000, 32'hC000_0000, 32'h0000_0001, 32'h5555_5555};
  localparam int V_X [NV] = '{1000, -2048, 2047, -1, 517, -1500, 1234, -777};

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", cyc, 0);
      summary();
    end
  end

  // R5 table definition
  function automatic int tableVal(input int a);
    int q, k, idx, m;
    q = (a >> 10) & 3;
    k = a & 1023;
    idx = (q & 1) ? 1023 - k : k;
    m = $rtoi(32767.0 * $sin(6.283185307179586 * (real'(idx) + 0.5) / 4096.0) + 0.5);
    return (q >= 2) ? -m : m;
  endfunction

  // R9 step and clamp
  function automatic int stepVal(input logic [1:0] s);
    if (s == 2'b01) return 1;
    if (s == 2'b10) return -1;
    return 0;
  endfunction

  function automatic int clampV(input int v);
    if (v > 32767) return 32767;
    if (v < -32767) return -32767;
    return v;
  endfunction

  task automatic sendSample(input int x, input string tag);
    logic [31:0] ph;
    logic [11:0] a;
    int st, sv, cv;
    longint eI, eQ;
    ph = accM + phaseOffset + (phaseDitherEn ? ({17'b0, lfsrM} << 5) : 32'd0);
    a = ph[31:20];
    st = ampDitherEn ? stepVal(lfsrM[1:0]) : 0;
    sv = clampV(tableVal(int'(a)) + st);
    cv = clampV(tableVal(int'(12'(a + 12'd1024))) + st);
    eI = (longint'(x) * longint'(cv) + 1024) >>> 11;
    eQ = (-(longint'(x) * longint'(sv)) + 1024) >>> 11;
    qI.push_back(int'(eI));
    qQ.push_back(int'(eQ));
    qCyc.push_back(cyc + 4);
    qTag.push_back(tag);
    inSample = 12'(x);
    inValid = 1'b1;
    accM = accM + freqWord;
    lfsrM = {lfsrM[13:0], lfsrM[14] ^ lfsrM[13]};
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic doClear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    accM = '0;
    lfsrM = 15'd1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Output monitor: latency then value
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (qI.size() == 0) begin
        check(1'b0, "R2", "output without input", 1, 0);
      end else begin
        int eI, eQ, eC;
        string tg;
        eI = qI.pop_front();
        eQ = qQ.pop_front();
        eC = qCyc.pop_front();
        tg = qTag.pop_front();
        check(cyc == eC, "R2", "latency cycle", cyc, eC);
        check(int'($signed(outI)) == eI, tg, "outI", int'($signed(outI)), eI);
        check(int'($signed(outQ)) == eQ, tg, "outQ", int'($signed(outQ)), eQ);
      end
    end
  end

  initial begin
    // R1 reset state
    idle(3);
    check(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    check(outI == '0, "R1", "outI in reset", outI, 0);
    check(outQ == '0, "R1", "outQ in reset", outQ, 0);
    rstN = 1'b1;
    idle(3);
    check(outValid == 1'b0 && outI == '0 && outQ == '0, "R1", "idle after reset", outValid, 0);

    // Vector table: R3 R4 R5 R6 across quadrants and offsets
    for (int v = 0; v < NV; v++) begin
      freqWord = V_FREQ[v];
      phaseOffset = V_OFF[v];
      doClear();
      sendSample(V_X[v], "R3 R4 R5 R6");
      sendSample(-V_X[v] - 1, "R3 R4 R5 R6");
      sendSample(V_X[v] / 2, "R3 R4 R5 R6");
      sendSample(V_X[v], "R3 R4 R5 R6");
      idle(6);
    end

    // R2 gaps and hold; R3 accumulator holds over idle cycles
    freqWord = 32'h0321_0000;
    phaseOffset = 32'h0;
    doClear();
    for (int g = 0; g < 6; g++) begin
      sendSample(300 * g - 800, "R2 R3");
      idle(g);
    end
    idle(8);

    // R6 zero sample
    sendSample(0, "R6");
    idle(6);

    // R7 clear mid-stream, including a sample in the clear cycle
    freqWord = 32'h0777_7777;
    sendSample(1111, "R7");
    sendSample(-999, "R7");
    inSample = 12'(2000);
    begin
      logic [31:0] ph;
      ph = accM + phaseOffset;
      qI.push_back(int'((longint'(2000) * tableVal(int'(12'(ph[31:20] + 12'd1024))) + 1024) >>> 11));
      qQ.push_back(int'((-(longint'(2000) * tableVal(int'(ph[31:20]))) + 1024) >>> 11));
      qCyc.push_back(cyc + 4);
      qTag.push_back("R7");
      inValid = 1'b1;
      doClear();
      inValid = 1'b0;
    end
    sendSample(1500, "R7");
    sendSample(-1500, "R7");
    idle(8);

    // R8 phase dither on, after the register has been stepping with dither off
    phaseDitherEn = 1'b1;
    freqWord = 32'h0135_7913;
    for (int n = 0; n < 40; n++) sendSample((n * 97) % 4096 - 2048, "R8");
    idle(6);
    phaseDitherEn = 1'b0;

    // R9 amplitude dither at sine peak (clamp) and elsewhere
    ampDitherEn = 1'b1;
    freqWord = 32'h0;
    phaseOffset = 32'h3FF0_0000;
    for (int n = 0; n < 24; n++) sendSample(2047, "R9");
    phaseOffset = 32'h0000_0000;
    for (int n = 0; n < 24; n++) sendSample(-2048, "R9");
    freqWord = 32'h0246_8ACE;
    phaseDitherEn = 1'b1;
    for (int n = 0; n < 30; n++) sendSample(1900 - n * 120, "R8 R9");
    phaseDitherEn = 1'b0;
    ampDitherEn = 1'b0;
    idle(8);

    check(qI.size() == 0, "R2", "pending outputs at end", qI.size(), 0);
    summary();
  end

endmodule